// File: doc/BRIEF.md
# Coin Credit Dispense Controller

This block is a small synchronous controller for a dispenser that sells one item priced at 15 units. It takes single-cycle pulses from a coin sensor for 5-unit and 10-unit coins and keeps the running credit in a two-bit state register. The credit never goes above the price, and the block gives no change. Once the price is reached, a release output asks the dispense mechanism to act.

The release output comes in two forms from one credit machine. The first is a state-decoded (Moore) output. The second is a Mealy term computed from the credit and the incoming coin, then passed through an output register so that it moves only at a clock edge and cannot glitch. The two forms can be compared cycle by cycle. The register absorbs the one-cycle lead of the raw Mealy term, so both releases rise on the same edge.

Top module: `coin_vend_fsm`

## Requirements
- R1: Reset is synchronous and active high. A clock edge with reset high sets the credit to 0 and clears both release outputs, whatever the credit or coin inputs were.
- R2: The credit levels 0, 5, 10 and 15 are held as state codes 00, 01, 10 and 11. At a clock edge a lone 5-unit pulse moves the credit to min(credit+5, 15), and a lone 10-unit pulse moves it to min(credit+10, 15).
- R3: With neither coin pulse asserted, the credit is unchanged at the clock edge.
- R4: If both coin pulses are asserted in the same cycle, the edge ignores both and the credit holds.
- R5: Once the credit is 15 it stays at 15 for any coin input until a reset edge.
- R6: The state-decoded release output is 1 exactly while the credit is 15.
- R7: The registered Mealy release is set at an edge where its raw term is 1 and cleared otherwise. The raw term is 1 when the credit is 10 and a lone 5-unit pulse arrives, or when the credit is 5 or 10 and a lone 10-unit pulse arrives, or when the credit is 15. As a result the registered Mealy release equals the state-decoded release in every cycle after reset.
- R8: Both release outputs are 0 during the cycle in which the coin that completes the price is presented. Both become 1 after the next clock edge, so the raw Mealy term leads them by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| coin5_i | input | 1 | One-cycle pulse for an accepted 5-unit coin |
| coin10_i | input | 1 | One-cycle pulse for an accepted 10-unit coin |
| vend_moore_o | output | 1 | Release decoded from the credit state |
| vend_mealy_o | output | 1 | Registered Mealy release |

## Verification
The credit is hidden, so a wrong credit value shows up only as a release that comes one coin early, one coin late, or never. The bench therefore follows each coin sequence up to the coin that should complete the price and checks that the release stays low until that coin and goes high on the edge after it. A lost or doubled increment, or a wrong response to simultaneous pulses, then shows within at most two further coins. A mismatch between the two release forms would appear on the very cycle the credit reaches 15 or leaves it at reset.

// File: rtl/coin_vend_fsm.sv
module coin_vend_fsm (
  input  logic clk_i,
  input  logic rst_i,
  input  logic coin5_i,
  input  logic coin10_i,
  output logic vend_moore_o,
  output logic vend_mealy_o
);

  typedef enum logic [1:0] {
    CR0  = 2'b00,
    CR5  = 2'b01,
    CR10 = 2'b10,
    CR15 = 2'b11
  } credit_t;

  credit_t cr_q, cr_d;
  logic    mealy_q;
  logic    one_coin, lone5, lone10, mealy_now;

  assign one_coin = coin5_i ^ coin10_i;
  assign lone5    = one_coin & coin5_i;
  assign lone10   = one_coin & coin10_i;

  always_comb begin
    cr_d = cr_q;
    if (cr_q != CR15) begin
      if (lone5)
        cr_d = credit_t'(cr_q + 2'd1);
      else if (lone10)
        cr_d = (cr_q == CR0) ? CR10 : CR15;
    end
  end

  assign mealy_now = (cr_q == CR15)
                   | (lone5  & (cr_q == CR10))
                   | (lone10 & ((cr_q == CR5) | (cr_q == CR10)));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cr_q    <= CR0;
      mealy_q <= 1'b0;
    end else begin
      cr_q    <= cr_d;
      mealy_q <= mealy_now;
    end
  end

  assign vend_moore_o = (cr_q == CR15);
  assign vend_mealy_o = mealy_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (cr_q == CR0) && !vend_mealy_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!coin5_i && !coin10_i) |=> $stable(cr_q));

  // R4
  both_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (coin5_i && coin10_i) |=> $stable(cr_q));

  // R5
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cr_q == CR15) |=> (cr_q == CR15));

  // R2
  nickel_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cr_q == CR0 && lone5) |=> (cr_q == CR5));

  // R7
  forms_agree_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    vend_mealy_o == vend_moore_o);

endmodule

// File: tb/coin_vend_fsm_bench.sv
module coin_vend_fsm_bench;
  logic clk = 1'b0;
  logic rst, c5, c10;
  logic moore, mealy;
  int total = 0;
  int bad = 0;
  bit timed_out = 1'b0;

  always #10 clk = ~clk;

  coin_vend_fsm u_coin_vend_fsm (
    .clk_i(clk), .rst_i(rst), .coin5_i(c5), .coin10_i(c10),
    .vend_moore_o(moore), .vend_mealy_o(mealy)
  );

  task automatic check(input string tag, input logic exp);
    total++;
    if (moore !== exp || mealy !== exp) begin
      bad++;
      $display("FAIL %s: moore=%b mealy=%b expected=%b", tag, moore, mealy, exp);
    end
  endtask

  // drive at a negedge, hold over one posedge, return at the next negedge
  task automatic step(input logic n, input logic d, input logic r);
    c5 = n; c10 = d; rst = r;
    @(posedge clk);
    @(negedge clk);
    c5 = 1'b0; c10 = 1'b0; rst = 1'b0;
  endtask

  task automatic do_reset();
    step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 after reset", 1'b0);
  endtask

  task automatic t_three_nickels();
    do_reset();
    step(1, 0, 0); check("R2 credit 5", 1'b0);
    step(1, 0, 0); check("R2 credit 10", 1'b0);
    c5 = 1'b1; #1; check("R8 completing coin present, outputs low", 1'b0);
    step(1, 0, 0); check("R6 R7 R8 release after third nickel", 1'b1);
  endtask

  task automatic t_nickel_dime();
    do_reset();
    step(1, 0, 0); check("R2 credit 5", 1'b0);
    c10 = 1'b1; #1; check("R8 dime present, outputs low", 1'b0);
    step(0, 1, 0); check("R7 credit 5 plus dime releases", 1'b1);
  endtask

  task automatic t_dime_nickel();
    do_reset();
    step(0, 1, 0); check("R2 credit 10 after dime", 1'b0);
    step(1, 0, 0); check("R7 credit 10 plus nickel releases", 1'b1);
  endtask

  task automatic t_two_dimes();
    do_reset();
    step(0, 1, 0); check("R2 one dime", 1'b0);
    step(0, 1, 0); check("R2 saturate at 15 on second dime", 1'b1);
  endtask

  task automatic t_idle_hold();
    do_reset();
    step(1, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    check("R3 credit 5 held while idle", 1'b0);
    step(0, 1, 0); check("R3 held credit completes with dime", 1'b1);
  endtask

  task automatic t_both_ignored();
    do_reset();
    step(1, 1, 0); check("R4 both at credit 0 ignored", 1'b0);
    step(0, 1, 0); check("R4 credit 10 after dime", 1'b0);
    step(1, 1, 0); check("R4 both at credit 10 ignored", 1'b0);
    step(1, 1, 0); check("R4 both repeated still ignored", 1'b0);
    step(1, 0, 0); check("R4 credit was 10, nickel releases", 1'b1);
  endtask

  task automatic t_both_at_five();
    do_reset();
    step(1, 0, 0);
    step(1, 1, 0); check("R4 both at credit 5 ignored", 1'b0);
    step(1, 0, 0); check("R4 credit 10 after nickel", 1'b0);
    step(1, 0, 0); check("R4 release at 15", 1'b1);
  endtask

  task automatic t_sticky();
    do_reset();
    step(0, 1, 0); step(0, 1, 0);
    step(0, 0, 0); check("R5 stays 15 idle", 1'b1);
    step(1, 0, 0); check("R5 stays 15 nickel", 1'b1);
    step(0, 1, 0); check("R5 stays 15 dime", 1'b1);
    step(1, 1, 0); check("R5 stays 15 both", 1'b1);
    c5 = 1'b1; c10 = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    c5 = 1'b0; c10 = 1'b0; rst = 1'b0;
    check("R1 reset clears from 15 despite coins", 1'b0);
    step(1, 0, 0); check("R1 R2 credit restarts at 0", 1'b0);
  endtask

  initial begin
    c5 = 1'b0; c10 = 1'b0; rst = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_three_nickels();
    t_nickel_dime();
    t_dime_nickel();
    t_two_dimes();
    t_idle_hold();
    t_both_ignored();
    t_both_at_five();
    t_sticky();
    if (!timed_out) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    timed_out = 1'b1;
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule